// File: doc/BRIEF.md
# Serial Quad-Channel DAC Register Controller

This block is the digital front end of a four-channel 8-bit converter. A host writes 12-bit command words over a three-wire serial link made of an active-low select, a shift clock and a data line. Each accepted word writes an 8-bit code into one of four input registers and can also change the power-down state of one channel or of all of them. A separate active-low load strobe makes the output registers follow the input registers, so that all four channels can change together. An asynchronous active-low clear zeroes every code register.

All five link and control pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser, and edges are detected on the synchronised copies. The outputs are four 8-bit codes and four enable flags for the analog stage. An enable flag that is low means the channel is powered down. Its stored code is still kept.

Top module: `qdac_serial_ctrl`

## Requirements
- R1: After reset, all four output codes read 0x00 and all four enable flags read 1.
- R2: A word is shifted in MSB first. Bit 11 is a power-down-all flag and is active low. Bit 10 is a power-down-addressed flag and is active low. Bits 9..8 select the channel: 0 is A, 1 is B, 2 is C, 3 is D. Bits 7..0 hold the code. On the rising edge of the select line, the code is written to the selected input register.
- R3: A bit is shifted only on a rising shift-clock edge while select is low. Clock edges while select is high have no effect.
- R4: When more than 12 bits arrive in one frame, only the last 12 are decoded.
- R5: A frame with fewer than 12 shift edges before select rises changes no register and no enable flag.
- R6: An accepted word with bit 11 at 0 clears all four enable flags.
- R7: When bit 11 is 1 and bit 10 is 0, an accepted word clears only the enable flag of the addressed channel.
- R8: A power-down word still stores its code. A word with bits 11 and 10 both at 1 sets the enable flag of the addressed channel only, and that channel's stored code is what appears.
- R9: While load is low, each output code copies its input register one clock later. While load is high, the output codes hold even when new words arrive.
- R10: While clear is low, every input and output code is 0x00. The shift register and bit count are not touched, so a frame already in progress completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_pin | input | 1 | Serial select, active low, asynchronous |
| sck_pin | input | 1 | Serial shift clock, asynchronous |
| sdat_pin | input | 1 | Serial data, asynchronous |
| load_n_pin | input | 1 | Output-register load strobe, active low, level sensitive |
| clr_n_pin | input | 1 | Code clear, active low, asynchronous |
| dac_code | output | 32 | Four output codes, channel A in bits 7..0 up to D in bits 31..24 |
| dac_oe | output | 4 | Enable flags, bit 0 = channel A; 0 means powered down |

## Verification
The bench sends shift-clock pulses while select is high and then closes a 4-bit frame. A design that counts or shifts those pulses would accept a corrupt word. It sends 16-bit frames with junk leading bits, which a design that keeps the first 12 bits would misdecode. It issues the power-down variants and wake-ups in a mixed order, so that a design that drops the code during power-down, or wakes every channel at once, shows the wrong enables or codes. It also pulses clear in the middle of a frame and with load high. A design that wipes the shift state on clear would lose the pending word, and one that lets outputs move while load is high would change codes early.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  typedef enum logic [1:0] {
    PD_ALL  = 2'd0,
    PD_ONE  = 2'd1,
    PD_WAKE = 2'd2
  } pd_op_e;

  function automatic pd_op_e decode_pd(input logic all_n, input logic one_n);
    if (!all_n)      return PD_ALL;
    else if (!one_n) return PD_ONE;
    else             return PD_WAKE;
  endfunction
endpackage

// File: rtl/qdac_sync2.sv
module qdac_sync2 #(
  parameter int          WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lvl_n,
  input  logic              sel_rise,
  input  logic              sck_rise,
  input  logic              sdat,
  output logic [WORD_W-1:0] word,
  output logic              word_vld
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              shift_en;

  assign shift_en = sck_rise && !sel_lvl_n;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (sel_rise) begin
      cnt_d = '0;
    end else if (shift_en) begin
      sr_d = {sr_q[WORD_W-2:0], sdat};
      if (cnt_q != CNT_FULL) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign word     = sr_q;
  assign word_vld = sel_rise && (cnt_q == CNT_FULL);
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank
  import qdac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_n,
  input  logic                     load_n,
  input  logic                     wr_en,
  input  pd_op_e                   pd_op,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CODE_W-1:0]        wr_code,
  output logic [NUM_CH*CODE_W-1:0] code_out,
  output logic [NUM_CH-1:0]        oe
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CODE_W-1:0] in_q, in_d;
    logic [CODE_W-1:0] out_q, out_d;
    logic              pd_q, pd_d;
    logic              hit;

    assign hit = wr_en && (wr_addr == ADDR_W'(ch));

    always_comb begin
      in_d  = in_q;
      out_d = out_q;
      pd_d  = pd_q;
      if (hit) in_d = wr_code;
      if (wr_en) begin
        case (pd_op)
          PD_ALL:  pd_d = 1'b1;
          PD_ONE:  if (hit) pd_d = 1'b1;
          default: if (hit) pd_d = 1'b0;
        endcase
      end
      if (!clr_n) begin
        in_d  = '0;
        out_d = '0;
      end else if (!load_n) begin
        out_d = in_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= '0;
        out_q <= '0;
        pd_q  <= 1'b0;
      end else begin
        in_q  <= in_d;
        out_q <= out_d;
        pd_q  <= pd_d;
      end
    end

    assign code_out[ch*CODE_W +: CODE_W] = out_q;
    assign oe[ch] = !pd_q;
  end
endmodule

// File: rtl/qdac_serial_ctrl.sv
module qdac_serial_ctrl
  import qdac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_n_pin,
  input  logic                     sck_pin,
  input  logic                     sdat_pin,
  input  logic                     load_n_pin,
  input  logic                     clr_n_pin,
  output logic [NUM_CH*CODE_W-1:0] dac_code,
  output logic [NUM_CH-1:0]        dac_oe
);
  localparam int ADDR_W = $clog2(NUM_CH);
  localparam int WORD_W = 2 + ADDR_W + CODE_W;
  localparam int B_ALL  = WORD_W - 1;
  localparam int B_ONE  = WORD_W - 2;
  // synchroniser lanes: {clr_n, load_n, sdat, sck, sel_n}
  localparam logic [4:0] SYNC_RST = 5'b11001;

  logic [4:0] pins_sync;
  logic       s_sel_n, s_sck, s_sdat, s_load_n, s_clr_n;
  logic       prev_sel_n, prev_sck;
  logic       sel_rise, sck_rise;
  logic [WORD_W-1:0] word;
  logic       word_vld;
  pd_op_e     pd_op;

  qdac_sync2 #(.WIDTH(5), .RST_VAL(SYNC_RST)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({clr_n_pin, load_n_pin, sdat_pin, sck_pin, sel_n_pin}),
    .q_sync  (pins_sync)
  );

  assign {s_clr_n, s_load_n, s_sdat, s_sck, s_sel_n} = pins_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel_n <= 1'b1;
      prev_sck   <= 1'b0;
    end else begin
      prev_sel_n <= s_sel_n;
      prev_sck   <= s_sck;
    end
  end

  assign sel_rise = s_sel_n && !prev_sel_n;
  assign sck_rise = s_sck && !prev_sck;

  qdac_frame_rx #(.WORD_W(WORD_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_lvl_n (s_sel_n),
    .sel_rise  (sel_rise),
    .sck_rise  (sck_rise),
    .sdat      (s_sdat),
    .word      (word),
    .word_vld  (word_vld)
  );

  assign pd_op = decode_pd(word[B_ALL], word[B_ONE]);

  qdac_chan_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (s_clr_n),
    .load_n   (s_load_n),
    .wr_en    (word_vld),
    .pd_op    (pd_op),
    .wr_addr  (word[CODE_W +: ADDR_W]),
    .wr_code  (word[CODE_W-1:0]),
    .code_out (dac_code),
    .oe       (dac_oe)
  );
endmodule

// File: rtl/qdac_serial_ctrl_chk.sv
module qdac_serial_ctrl_chk #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8,
  parameter int WORD_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sel_rise,
  input logic                     word_vld,
  input logic [WORD_W-1:0]        word,
  input logic                     s_clr_n,
  input logic                     s_load_n,
  input logic [NUM_CH*CODE_W-1:0] dac_code,
  input logic [NUM_CH-1:0]        dac_oe
);
  localparam int AW = $clog2(NUM_CH);

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n) !s_clr_n |=> dac_code == '0); // R10
  AST_LOAD_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (s_load_n && s_clr_n) |=> $stable(dac_code)); // R9
  AST_SHORT_FRAME_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (sel_rise && !word_vld) |=> $stable(dac_oe)); // R5
  AST_OE_ONLY_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n) !word_vld |=> $stable(dac_oe)); // R3
  AST_PD_ALL: assert property (@(posedge clk) disable iff (!rst_n) (word_vld && !word[WORD_W-1]) |=> dac_oe == '0); // R6
  AST_PD_ONE: assert property (@(posedge clk) disable iff (!rst_n) (word_vld && word[WORD_W-1] && !word[WORD_W-2]) |=> dac_oe[$past(word[CODE_W +: AW])] == 1'b0); // R7
  AST_WAKE_ONE: assert property (@(posedge clk) disable iff (!rst_n) (word_vld && word[WORD_W-1] && word[WORD_W-2]) |=> dac_oe[$past(word[CODE_W +: AW])] == 1'b1); // R8
endmodule

bind qdac_serial_ctrl qdac_serial_ctrl_chk #(
  .NUM_CH (NUM_CH),
  .CODE_W (CODE_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_rise (sel_rise),
  .word_vld (word_vld),
  .word     (word),
  .s_clr_n  (s_clr_n),
  .s_load_n (s_load_n),
  .dac_code (dac_code),
  .dac_oe   (dac_oe)
);

// File: tb/sim_qdac_serial_ctrl.sv
`timescale 1ns/1ps
module sim_qdac_serial_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, sck = 1'b0, sdat = 1'b0, load_n = 1'b1, clr_n = 1'b1;
  logic [31:0] dac_code;
  logic [3:0]  dac_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  qdac_serial_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sel_n_pin(sel_n), .sck_pin(sck), .sdat_pin(sdat),
    .load_n_pin(load_n), .clr_n_pin(clr_n), .dac_code(dac_code), .dac_oe(dac_oe)
  );

  // ---------------- behavioural reference model ----------------
  // sample layout: {clr_n, load_n, sdat, sck, sel_n}
  logic [4:0] hist[$];
  int  m_cnt, m_sr;
  int  m_in[4], m_out[4];
  bit  m_pd[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {5'b11001, 5'b11001, 5'b11001, 5'b11001};
      m_cnt = 0; m_sr = 0;
      foreach (m_in[i]) begin m_in[i] = 0; m_out[i] = 0; m_pd[i] = 0; end
    end else begin
      logic [4:0] now, old;
      int n_in[4];
      bit sel_up, sck_up;
      hist.push_back({clr_n, load_n, sdat, sck, sel_n});
      if (hist.size() > 8) void'(hist.pop_front());
      now = hist[hist.size()-3];
      old = hist[hist.size()-4];
      sel_up = now[0] && !old[0];
      sck_up = now[1] && !old[1];
      n_in = m_in;
      if (sel_up) begin
        if (m_cnt >= 12) begin
          int a;
          a = (m_sr >> 8) & 3;
          n_in[a] = m_sr & 255;
          if (((m_sr >> 11) & 1) == 0) foreach (m_pd[i]) m_pd[i] = 1;
          else if (((m_sr >> 10) & 1) == 0) m_pd[a] = 1;
          else m_pd[a] = 0;
        end
        m_cnt = 0;
      end else if (sck_up && !now[0]) begin
        m_sr = ((m_sr << 1) | int'(now[2])) & 12'hFFF;
        if (m_cnt < 12) m_cnt++;
      end
      if (!now[4]) begin
        foreach (n_in[i]) begin n_in[i] = 0; m_out[i] = 0; end
      end else if (!now[3]) begin
        m_out = m_in;
      end
      m_in = n_in;
    end
  end

  function automatic void chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] ec;
      logic [3:0]  eo;
      for (int i = 0; i < 4; i++) begin
        ec[i*8 +: 8] = 8'(m_out[i]);
        eo[i] = !m_pd[i];
      end
      chk({phase, " model code"}, dac_code, ec);
      chk({phase, " model oe"}, {28'd0, dac_oe}, {28'd0, eo});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [15:0] val, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = val[i];
      idle(3);
      sck = 1'b1;
      idle(3);
      sck = 1'b0;
    end
  endtask

  task automatic frame(logic [15:0] val, int n);
    sel_n = 1'b0;
    idle(3);
    shift_bits(val, n);
    idle(3);
    sel_n = 1'b1;
    idle(8);
  endtask

  task automatic word12(logic all_n, logic one_n, logic [1:0] ch, logic [7:0] code);
    frame({4'd0, all_n, one_n, ch, code}, 12);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    phase = "R1";
    chk("R1 codes after reset", dac_code, 32'h0);
    chk("R1 enables after reset", {28'd0, dac_oe}, 32'hF);

    phase = "R2";
    load_n = 1'b0;
    idle(4);
    word12(1, 1, 2'd0, 8'hA5);
    word12(1, 1, 2'd1, 8'h3C);
    word12(1, 1, 2'd2, 8'h81);
    word12(1, 1, 2'd3, 8'h7E);
    chk("R2 four channels written", dac_code, 32'h7E813CA5);

    phase = "R3";
    for (int i = 0; i < 12; i++) begin
      sdat = i[0]; idle(3); sck = 1'b1; idle(3); sck = 1'b0;
    end
    idle(4);
    frame(16'h0, 4);
    chk("R3 edges with select high ignored", dac_code, 32'h7E813CA5);
    chk("R3 enables unchanged", {28'd0, dac_oe}, 32'hF);

    phase = "R5";
    frame(16'h0_55, 11);
    chk("R5 eleven-bit frame ignored", dac_code, 32'h7E813CA5);
    chk("R5 enables after short frame", {28'd0, dac_oe}, 32'hF);

    phase = "R4";
    frame(16'hA_D77, 16);
    chk("R4 last 12 of 16 bits decoded", dac_code, 32'h7E8177A5);

    phase = "R6";
    word12(0, 1, 2'd2, 8'h11);
    chk("R6 all channels powered down", {28'd0, dac_oe}, 32'h0);
    chk("R8 code stored while down", dac_code, 32'h7E1177A5);

    phase = "R8";
    word12(1, 1, 2'd0, 8'h22);
    chk("R8 wake addressed channel only", {28'd0, dac_oe}, 32'h1);
    chk("R8 woken channel shows its code", dac_code[7:0], 32'h22);
    word12(1, 1, 2'd1, 8'h33);
    word12(1, 1, 2'd2, 8'h11);
    word12(1, 1, 2'd3, 8'h7E);
    chk("R8 all channels awake", {28'd0, dac_oe}, 32'hF);

    phase = "R7";
    word12(1, 0, 2'd1, 8'h44);
    chk("R7 only channel B down", {28'd0, dac_oe}, 32'hD);
    chk("R7 code B still stored", dac_code, 32'h7E114422);
    word12(0, 0, 2'd3, 8'h55);
    chk("R7 both bits low downs all", {28'd0, dac_oe}, 32'h0);
    for (int c = 0; c < 4; c++) word12(1, 1, 2'(c), 8'(8'h60 + c));
    chk("R7 recovery", {28'd0, dac_oe}, 32'hF);

    phase = "R9";
    load_n = 1'b1;
    idle(4);
    word12(1, 1, 2'd0, 8'h99);
    chk("R9 output holds with load high", dac_code, 32'h63626160);
    load_n = 1'b0;
    idle(5);
    chk("R9 load low copies inputs", dac_code, 32'h63626199);
    load_n = 1'b1;
    idle(4);
    word12(1, 1, 2'd0, 8'h10);
    chk("R9 latched after load rises", dac_code, 32'h63626199);

    phase = "R10";
    sel_n = 1'b0;
    idle(3);
    shift_bits(16'h0_E5E, 12);
    clr_n = 1'b0;
    idle(6);
    clr_n = 1'b1;
    idle(4);
    chk("R10 clear zeroes outputs", dac_code, 32'h0);
    sel_n = 1'b1;
    idle(8);
    load_n = 1'b0;
    idle(5);
    chk("R10 pending frame survives clear", dac_code, 32'h005E0000);
    chk("R10 enables untouched by clear", {28'd0, dac_oe}, 32'hF);

    idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule